// File: doc/BRIEF.md
# PWM Action Qualifier

This block decides the level of two PWM outputs, A and B, from event pulses produced by a time-base counter that lives outside it. The counter supplies single-cycle pulses when it reaches zero, when it reaches its period, and when it matches compare value A. It also supplies its count direction and whether it runs in up-down mode. For each output, a configuration byte gives a 2-bit action for each kind of event. The action can hold the output, drive it low, drive it high or invert it.

Software can also act on the outputs through a small register port. A one-time force applies a chosen action once, and any later event may override it. A continuous force holds an output low or high for as long as it is active. Its active value either loads from a shadow copy at chosen counter turning points or is written directly.

Top module: `pwm_action_qual`

## Requirements
- R1: The 2-bit action codes are 00 hold, 01 drive low, 10 drive high, 11 invert the present level. The output changes on the same clock edge that samples the event pulse.
- R2: Output A takes its configuration byte from address 0 and output B from address 1. In that byte, bits 1:0 hold the zero action, 3:2 the period action, 5:4 the compare-while-up action and 7:6 the compare-while-down action.
- R3: A compare event uses the up field when cnt_dir is 1 and the down field when it is 0. In up-down mode, a compare that coincides with a zero pulse uses the up field, and one that coincides with a period pulse uses the down field, whatever cnt_dir says.
- R4: When several events fall in one cycle, only the highest-ranked one decides the output, even if its code is 00. The ranking from highest is: one-time force, then compare, then period, then zero.
- R5: The control word at address 2 holds one-time force bits at bit 2 (A) and bit 5 (B). Writing 1 to one of these applies that output's software action (bits 1:0 for A, 4:3 for B) on the next clock edge after the write. Writing 0 does nothing, and these bits always read as 0.
- R6: A level set by a one-time force holds only until a later event on that output applies its own action.
- R7: The continuous force at address 3 uses bits 1:0 for A and 3:2 for B. Its codes are 00 none, 01 low, 10 high and 11 disabled. An active low or high force overrides every other action on that output from the edge after the active value takes it.
- R8: Control word bits 7:6 select how the active force value is reloaded: 00 from the shadow at a zero pulse, 01 at a period pulse, 10 at either pulse. With 11, a write to address 3 sets the active value directly on the write edge. Address 3 reads the shadow and address 4 reads the active value.
- R9: rd_data shows the register selected by rd_addr one clock later. Control word bits 15:8 and any unused address read as 0.
- R10: A synchronous reset clears both outputs, all registers and rd_data to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_updown | input | 1 | Counter runs in up-down mode |
| cnt_dir | input | 1 | Counter direction, 1 = up |
| evt_zero | input | 1 | Counter-at-zero pulse |
| evt_prd | input | 1 | Counter-at-period pulse |
| evt_cmpa | input | 1 | Counter-equals-compare-A pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Registered read data |
| pwm_a | output | 1 | Output A |
| pwm_b | output | 1 | Output B |

## Verification
The outputs are registered one edge after their cause. A wrong action decode, ranking or direction choice therefore shows as a wrong pwm_a or pwm_b level on the first edge that samples the event. A missed one-time force or a stale force value shows one edge after the write or reload. A wrong shadow or active force value is also visible through addresses 3 and 4 one clock after it is selected. A bench model that is compared on every edge catches each of these within a cycle of its cause.

// File: rtl/pwm_aq_pkg.sv
`timescale 1ns/1ps
package pwm_aq_pkg;
  localparam int NCH   = 2;
  localparam int CFG_W = 8;

  typedef enum logic [1:0] {ACT_HOLD = 2'b00, ACT_LOW = 2'b01, ACT_HIGH = 2'b10, ACT_TOGGLE = 2'b11} act_e;
  typedef enum logic [1:0] {RLD_ZERO = 2'b00, RLD_PRD = 2'b01, RLD_EITHER = 2'b10, RLD_DIRECT = 2'b11} rld_e;
  typedef enum logic [1:0] {FRC_NONE = 2'b00, FRC_LOW = 2'b01, FRC_HIGH = 2'b10, FRC_OFF = 2'b11} frc_e;

  function automatic logic act_apply(input logic [1:0] code, input logic cur);
    case (act_e'(code))
      ACT_LOW:    return 1'b0;
      ACT_HIGH:   return 1'b1;
      ACT_TOGGLE: return ~cur;
      default:    return cur;
    endcase
  endfunction
endpackage

// File: rtl/pwm_aq_regs.sv
`timescale 1ns/1ps
module pwm_aq_regs
  import pwm_aq_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        evt_zero,
  input  logic                        evt_prd,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [DATA_W-1:0]           wr_data,
  input  logic [ADDR_W-1:0]           rd_addr,
  output logic [DATA_W-1:0]           rd_data,
  output logic [NCH-1:0][CFG_W-1:0]   evt_cfg,
  output logic [NCH-1:0][1:0]         sw_act,
  output logic [NCH-1:0]              os_pulse,
  output logic [NCH-1:0][1:0]         frc_act
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(NCH);
  localparam logic [ADDR_W-1:0] A_FSH  = ADDR_W'(NCH + 1);
  localparam logic [ADDR_W-1:0] A_FACT = ADDR_W'(NCH + 2);
  localparam int FRC_W = 2 * NCH;

  rld_e                 rld_q;
  logic [NCH-1:0][1:0]  frc_sh;
  logic                 reload_hit;
  logic                 wr_ctrl, wr_fsh;
  logic [DATA_W-1:0]    rd_mux;
  logic                 unused_wr_hi;

  assign unused_wr_hi = ^wr_data[DATA_W-1:CFG_W];
  assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
  assign wr_fsh  = wr_en && (wr_addr == A_FSH);

  always_comb begin
    reload_hit = 1'b0;
    case (rld_q)
      RLD_ZERO:   reload_hit = evt_zero;
      RLD_PRD:    reload_hit = evt_prd;
      RLD_EITHER: reload_hit = evt_zero || evt_prd;
      default:    reload_hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_cfg  <= '0;
      sw_act   <= '0;
      os_pulse <= '0;
      rld_q    <= RLD_ZERO;
      frc_sh   <= '0;
      frc_act  <= '0;
    end else begin
      os_pulse <= '0;
      for (int c = 0; c < NCH; c++) begin
        if (wr_en && (wr_addr == ADDR_W'(c))) evt_cfg[c] <= wr_data[CFG_W-1:0];
      end
      if (wr_ctrl) begin
        rld_q <= rld_e'(wr_data[7:6]);
        for (int c = 0; c < NCH; c++) begin
          sw_act[c]   <= wr_data[3*c +: 2];
          os_pulse[c] <= wr_data[3*c + 2];
        end
      end
      if (wr_fsh) frc_sh <= wr_data[FRC_W-1:0];
      if (wr_fsh && (rld_q == RLD_DIRECT)) frc_act <= wr_data[FRC_W-1:0];
      else if (reload_hit)                 frc_act <= frc_sh;
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int c = 0; c < NCH; c++) begin
      if (rd_addr == ADDR_W'(c)) rd_mux[CFG_W-1:0] = evt_cfg[c];
    end
    if (rd_addr == A_CTRL) begin
      rd_mux[7:6] = rld_q;
      for (int c = 0; c < NCH; c++) rd_mux[3*c +: 2] = sw_act[c];
    end
    if (rd_addr == A_FSH)  rd_mux[FRC_W-1:0] = frc_sh;
    if (rd_addr == A_FACT) rd_mux[FRC_W-1:0] = frc_act;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_mux;
  end

  AST_OS_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_addr) == A_CTRL) |-> (rd_data[2] == 1'b0 && rd_data[5] == 1'b0)); // R5
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_addr) == A_CTRL) |-> (rd_data[DATA_W-1:CFG_W] == '0)); // R9
  AST_DIRECT_LOAD: assert property (@(posedge clk) disable iff (rst)
    (wr_fsh && rld_q == RLD_DIRECT) |=> (frc_act == $past(wr_data[FRC_W-1:0]))); // R8
  AST_RELOAD_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rld_q == RLD_ZERO && evt_zero && !wr_fsh) |=> (frc_act == $past(frc_sh))); // R8
endmodule

// File: rtl/pwm_aq_chan.sv
`timescale 1ns/1ps
module pwm_aq_chan
  import pwm_aq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             evt_zero,
  input  logic             evt_prd,
  input  logic             evt_cmpa,
  input  logic             cmpa_up,
  input  logic [CFG_W-1:0] cfg,
  input  logic [1:0]       sw_act,
  input  logic             os_pulse,
  input  logic [1:0]       frc,
  output logic             out_q
);
  logic [1:0] code;
  logic       evt_lvl;
  logic       nxt;
  logic       frc_on;

  always_comb begin
    if (os_pulse)      code = sw_act;
    else if (evt_cmpa) code = cmpa_up ? cfg[5:4] : cfg[7:6];
    else if (evt_prd)  code = cfg[3:2];
    else if (evt_zero) code = cfg[1:0];
    else               code = ACT_HOLD;
    evt_lvl = act_apply(code, out_q);
  end

  assign frc_on = (frc == FRC_LOW) || (frc == FRC_HIGH);

  always_comb begin
    case (frc_e'(frc))
      FRC_LOW:  nxt = 1'b0;
      FRC_HIGH: nxt = 1'b1;
      default:  nxt = evt_lvl;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) out_q <= 1'b0;
    else     out_q <= nxt;
  end

  AST_FORCE_LOW: assert property (@(posedge clk) disable iff (rst)
    (frc == FRC_LOW) |=> !out_q); // R7
  AST_FORCE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (frc == FRC_HIGH) |=> out_q); // R7
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!evt_zero && !evt_prd && !evt_cmpa && !os_pulse && !frc_on) |=> $stable(out_q)); // R1
  AST_ONESHOT_HIGH: assert property (@(posedge clk) disable iff (rst)
    (os_pulse && sw_act == ACT_HIGH && !frc_on) |=> out_q); // R5
  AST_CMPA_BEATS_TURN: assert property (@(posedge clk) disable iff (rst)
    (evt_cmpa && !os_pulse && !frc_on && (cmpa_up ? cfg[5:4] : cfg[7:6]) == ACT_LOW) |=> !out_q); // R4
endmodule

// File: rtl/pwm_action_qual.sv
`timescale 1ns/1ps
module pwm_action_qual
  import pwm_aq_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cnt_updown,
  input  logic              cnt_dir,
  input  logic              evt_zero,
  input  logic              evt_prd,
  input  logic              evt_cmpa,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              pwm_a,
  output logic              pwm_b
);
  logic [NCH-1:0][CFG_W-1:0] evt_cfg;
  logic [NCH-1:0][1:0]       sw_act;
  logic [NCH-1:0]            os_pulse;
  logic [NCH-1:0][1:0]       frc_act;
  logic [NCH-1:0]            out_bus;
  logic                      cmpa_up;

  // Turning points fix the direction in up-down mode: zero counts as up, period as down.
  always_comb begin
    cmpa_up = cnt_dir;
    if (cnt_updown) begin
      if (evt_zero)     cmpa_up = 1'b1;
      else if (evt_prd) cmpa_up = 1'b0;
    end
  end

  pwm_aq_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .evt_zero(evt_zero), .evt_prd(evt_prd),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .evt_cfg(evt_cfg), .sw_act(sw_act),
    .os_pulse(os_pulse), .frc_act(frc_act)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    pwm_aq_chan u_chan (
      .clk(clk), .rst(rst), .evt_zero(evt_zero), .evt_prd(evt_prd),
      .evt_cmpa(evt_cmpa), .cmpa_up(cmpa_up), .cfg(evt_cfg[c]),
      .sw_act(sw_act[c]), .os_pulse(os_pulse[c]), .frc(frc_act[c]),
      .out_q(out_bus[c])
    );
  end

  assign pwm_a = out_bus[0];
  assign pwm_b = out_bus[1];
endmodule

// File: tb/pwm_action_qual_tb.sv
`timescale 1ns/1ps
module pwm_action_qual_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cnt_updown = 0, cnt_dir = 1, evt_zero = 0, evt_prd = 0, evt_cmpa = 0;
  logic        wr_en = 0;
  logic [2:0]  wr_addr = 0, rd_addr = 0;
  logic [15:0] wr_data = 0;
  logic [15:0] rd_data;
  logic        pwm_a, pwm_b;

  int vectors = 0, miscompares = 0;
  string tag = "R10";

  // behavioural reference state
  int m_cfg[2], m_sw[2], m_os[2], m_out[2];
  int m_rld = 0, m_sh = 0, m_fa = 0, m_rd = 0;

  always #10 clk = ~clk;

  pwm_action_qual u_dut (
    .clk(clk), .rst(rst), .cnt_updown(cnt_updown), .cnt_dir(cnt_dir),
    .evt_zero(evt_zero), .evt_prd(evt_prd), .evt_cmpa(evt_cmpa),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .pwm_a(pwm_a), .pwm_b(pwm_b)
  );

  function automatic int do_act(int code, int cur);
    if (code == 1) return 0;
    if (code == 2) return 1;
    if (code == 3) return 1 - cur;
    return cur;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_cfg[i]) begin m_cfg[i] = 0; m_sw[i] = 0; m_os[i] = 0; m_out[i] = 0; end
      m_rld = 0; m_sh = 0; m_fa = 0; m_rd = 0;
    end else begin
      int up, fv, code, reload;
      int nrd;
      up = cnt_dir;
      if (cnt_updown && evt_zero) up = 1;
      else if (cnt_updown && evt_prd) up = 0;
      for (int i = 0; i < 2; i++) begin
        if (m_os[i] != 0)   code = m_sw[i];
        else if (evt_cmpa)  code = up ? ((m_cfg[i] >> 4) & 3) : ((m_cfg[i] >> 6) & 3);
        else if (evt_prd)   code = (m_cfg[i] >> 2) & 3;
        else if (evt_zero)  code = m_cfg[i] & 3;
        else                code = 0;
        fv = (m_fa >> (2*i)) & 3;
        if (fv == 1)      m_out[i] = 0;
        else if (fv == 2) m_out[i] = 1;
        else              m_out[i] = do_act(code, m_out[i]);
      end
      case (rd_addr)
        0: nrd = m_cfg[0];
        1: nrd = m_cfg[1];
        2: nrd = (m_rld << 6) | (m_sw[1] << 3) | m_sw[0];
        3: nrd = m_sh;
        4: nrd = m_fa;
        default: nrd = 0;
      endcase
      m_rd = nrd;
      reload = (m_rld == 0 && evt_zero) || (m_rld == 1 && evt_prd) ||
               (m_rld == 2 && (evt_zero || evt_prd));
      m_os[0] = 0; m_os[1] = 0;
      if (wr_en && wr_addr <= 1) m_cfg[wr_addr] = wr_data & 'hFF;
      if (wr_en && wr_addr == 3 && m_rld == 3) m_fa = wr_data & 'hF;
      else if (reload) m_fa = m_sh;
      if (wr_en && wr_addr == 3) m_sh = wr_data & 'hF;
      if (wr_en && wr_addr == 2) begin
        m_rld = (wr_data >> 6) & 3;
        m_sw[0] = wr_data & 3; m_os[0] = (wr_data >> 2) & 1;
        m_sw[1] = (wr_data >> 3) & 3; m_os[1] = (wr_data >> 5) & 1;
      end
    end
  end

  task automatic compare();
    vectors++;
    if (pwm_a !== m_out[0][0]) begin
      miscompares++;
      $display("FAIL %s pwm_a got %0b expected %0d", tag, pwm_a, m_out[0]);
    end
    if (pwm_b !== m_out[1][0]) begin
      miscompares++;
      $display("FAIL %s pwm_b got %0b expected %0d", tag, pwm_b, m_out[1]);
    end
    if (rd_data !== 16'(m_rd)) begin
      miscompares++;
      $display("FAIL %s rd_data got %h expected %h", tag, rd_data, 16'(m_rd));
    end
  endtask

  task automatic cyc(int n = 1);
    repeat (n) begin
      @(posedge clk); #5; compare(); #5;
    end
  endtask

  task automatic wr(int a, int d);
    wr_en = 1; wr_addr = 3'(a); wr_data = 16'(d);
    cyc(1);
    wr_en = 0;
  endtask

  task automatic ev(bit z, bit p, bit c);
    evt_zero = z; evt_prd = p; evt_cmpa = c;
    cyc(1);
    evt_zero = 0; evt_prd = 0; evt_cmpa = 0;
  endtask

  task automatic rd(int a);
    rd_addr = 3'(a);
    cyc(2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired during %s", tag);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    // R10: reset state of outputs and registers
    tag = "R10";
    cyc(2);
    rst = 0;
    rd(0); rd(1); rd(2); rd(3); rd(4);

    // R2: per-output configuration bytes and readback
    tag = "R2";
    wr(0, 'h36); wr(1, 'hC9);
    rd(0); rd(1);

    // R1: each code on zero, period, compare up
    tag = "R1";
    ev(1, 0, 0); cyc(1);
    ev(0, 1, 0); cyc(1);
    ev(0, 0, 1); ev(0, 0, 1); ev(0, 0, 1);
    ev(1, 0, 0); ev(0, 1, 0);

    // R3: direction selection, plain and up-down turning points
    tag = "R3";
    cnt_dir = 0; ev(0, 0, 1); ev(0, 0, 1);
    cnt_dir = 1; ev(0, 0, 1);
    cnt_updown = 1;
    cnt_dir = 0; ev(1, 0, 1); ev(1, 0, 1);
    cnt_dir = 1; ev(0, 1, 1); ev(0, 1, 1);
    cnt_updown = 0;
    cnt_dir = 0; ev(1, 0, 1);
    cnt_dir = 1; ev(0, 1, 1);

    // R4: coincident events, highest rank decides
    tag = "R4";
    ev(1, 1, 0); ev(1, 1, 1); ev(1, 1, 1);
    wr(0, 'h02); ev(1, 0, 1); ev(1, 0, 0); ev(0, 0, 1);
    wr(0, 'h36);
    wr(2, 'h06); ev(1, 1, 1); cyc(1);
    wr(2, 'h20); ev(0, 0, 1); cyc(1);

    // R5: one-time force, zero writes inert, reads as zero
    tag = "R5";
    wr(2, 'h06); cyc(2);
    wr(2, 'h29); cyc(2);
    wr(2, 'h1B); cyc(2);
    rd(2);
    wr(2, 'h07); cyc(1); wr(2, 'h07); cyc(1);

    // R6: later event overrides a one-time level
    tag = "R6";
    wr(2, 'h05); cyc(1);
    ev(1, 0, 0); cyc(1);
    wr(2, 'h28); ev(0, 1, 0); cyc(1);

    // R7: continuous force overrides events, 11 disables
    tag = "R7";
    wr(2, 'hC0);
    wr(3, 'h9); rd(4);
    ev(1, 0, 0); ev(0, 1, 0); ev(0, 0, 1);
    wr(2, 'hE4); cyc(2);
    wr(3, 'hF); ev(0, 0, 1); ev(1, 0, 0);
    wr(3, 'h6); ev(0, 1, 1); cyc(1);
    wr(3, 'h0); ev(0, 0, 1); ev(1, 0, 0);

    // R8: reload modes from shadow
    tag = "R8";
    wr(2, 'h00); wr(3, 'h5); rd(3); rd(4);
    ev(0, 1, 0); rd(4);
    ev(1, 0, 0); rd(4);
    wr(2, 'h40); wr(3, 'hA); ev(1, 0, 0); rd(4);
    ev(0, 1, 0); rd(4);
    wr(2, 'h80); wr(3, 'h0); ev(1, 0, 0); rd(4);
    wr(3, 'h6); ev(0, 1, 0); rd(4);
    wr(3, 'h0); ev(1, 1, 0); rd(4);
    wr(2, 'hC0); wr(3, 'h9); rd(4); rd(3);
    wr(3, 'h0); rd(4);

    // R9: reserved bits and unused addresses read zero
    tag = "R9";
    wr(2, 'hFFFF); rd(2); rd(5); rd(6); rd(7);
    wr(0, 'hFFFF); rd(0);
    wr(2, 'h0000); wr(3, 'h0); ev(1, 0, 0);

    // R4: randomized mixed traffic, every rule at once
    tag = "R4";
    for (int k = 0; k < 4000; k++) begin
      if (k % 500 == 0) cnt_updown = 1'($urandom);
      cnt_dir  = 1'($urandom);
      evt_zero = ($urandom % 4) == 0;
      evt_prd  = ($urandom % 4) == 0;
      evt_cmpa = ($urandom % 3) == 0;
      wr_en    = ($urandom % 8) == 0;
      wr_addr  = 3'($urandom % 5);
      wr_data  = 16'($urandom);
      rd_addr  = 3'($urandom);
      cyc(1);
    end
    wr_en = 0; evt_zero = 0; evt_prd = 0; evt_cmpa = 0;

    // R10: reset mid-run clears everything again
    tag = "R10";
    rst = 1; cyc(2); rst = 0;
    rd(0); rd(2); rd(4);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule